// File: doc/BRIEF.md
# Flash Operation Status Toggle Logic

This block is the device-side status logic of a parallel NOR flash. While the flash controller runs an embedded program or erase, status reads return two toggle bits instead of array data. The busy bit inverts on every read while any embedded operation is running. The sector bit inverts only on reads that land in a sector marked for erase. Host software can combine the two. It can tell an active erase from a suspended one, and it can tell which sectors an erase covers.

The controller reports its state on `op_state`. It pulses `cmd_commit` on the final write-enable rising edge of a program or erase command sequence. The block compares the command target with the protection mask. A program aimed at a protected sector is aborted, and so is an erase whose selected sectors are all protected. An aborted command keeps the busy bit toggling for a fixed number of clock cycles, and the block then returns to array reads. A read strobe is a single-cycle pulse derived upstream from the rising edge of either output-enable or chip-enable. When `array_mode` is high, reads return array data and both toggle bits are held at zero.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset, `dq6` and `dq2` are 0 and `array_mode` is 1.
- R2: The `op_state` encoding is 0 idle, 1 program, 2 erase time-out, 3 erasing, 4 erase-suspended, 5 erase-suspend-program, and 6 and 7 act as idle. In states 1, 2, 3 and 5, each `rd_strobe` pulse inverts `dq6` from the following cycle on. Without a strobe, `dq6` keeps its value.
- R3: In state 4, with no abort running, `dq6` holds its value across read strobes.
- R4: The sector of an address is its top log2(NUM_SECT) bits. In states 2, 3, 4 and 5, and during an erase abort, a strobe whose `rd_addr` sector has its bit set in `erase_sel` inverts `dq2`.
- R5: A strobe to a sector not set in `erase_sel` leaves `dq2` unchanged. So does any strobe while no erase is pending, for example in state 1.
- R6: `array_mode` is 1 exactly when `op_state` acts as idle and no abort is running. While it is 1, `dq6` and `dq2` read 0 and both toggle flip-flops return to 0.
- R7: A `cmd_commit` pulse with `cmd_erase`=0 in array mode aborts the command when the `cmd_addr` sector is set in `prot_mask`. The abort lasts PROG_ABORT_CYC cycles from the commit edge. During it `array_mode` is 0 and `dq6` toggles per strobe. Afterwards `array_mode` is 1 again.
- R8: A `cmd_commit` pulse with `cmd_erase`=1 in array mode aborts the command when `erase_sel` is non-zero and every selected sector is protected. The abort lasts ERASE_ABORT_CYC cycles. During it `dq6` toggles per strobe, and `dq2` toggles per strobe to a selected sector.
- R9: No abort is started in three cases: an erase with at least one unprotected selected sector, an erase with an empty selection, and a program to an unprotected sector. A commit pulse received outside array mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_state | input | 3 | Embedded operation state from the controller |
| cmd_commit | input | 1 | Pulse on the final write of a command sequence |
| cmd_erase | input | 1 | Committed command is an erase (1) or a program (0) |
| cmd_addr | input | ADDR_W | Program target address |
| erase_sel | input | NUM_SECT | Sectors selected for erase |
| prot_mask | input | NUM_SECT | Protected sectors |
| rd_strobe | input | 1 | Single-cycle pulse per completed read cycle |
| rd_addr | input | ADDR_W | Address of the read |
| dq6 | output | 1 | Busy toggle bit |
| dq2 | output | 1 | Erase-sector toggle bit |
| array_mode | output | 1 | Reads return array data |

## Verification
The bench builds the block with eight sectors and a 12-bit address. The abort lengths are shortened to 40 cycles for erase and 6 for program, so both abort windows can be watched from start to end. The directed part then issues reads after each window closes, and so checks the exact cycle on which the block returns to array reads. A reference model in the bench predicts both bits for every sector and every state, including the unused state codes. Random reads, state changes and masks then reach combinations the directed sequences do not.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_PROG      = 3'd1,
        OP_ERS_WAIT  = 3'd2,
        OP_ERASE     = 3'd3,
        OP_ERS_SUSP  = 3'd4,
        OP_SUSP_PROG = 3'd5
    } op_state_e;

    typedef struct packed {
        logic busy_tog;
        logic sect_tog;
    } tog_state_t;

    // An embedded algorithm is running (busy bit advances)
    function automatic logic op_is_running(logic [2:0] st);
        return (st == OP_PROG) || (st == OP_ERS_WAIT) ||
               (st == OP_ERASE) || (st == OP_SUSP_PROG);
    endfunction

    // An erase is pending, active or suspended (sector bit may advance)
    function automatic logic op_erase_pending(logic [2:0] st);
        return (st == OP_ERS_WAIT) || (st == OP_ERASE) ||
               (st == OP_ERS_SUSP) || (st == OP_SUSP_PROG);
    endfunction

    // Codes 0, 6 and 7 behave as idle
    function automatic logic op_is_idle(logic [2:0] st);
        return !(op_is_running(st) || (st == OP_ERS_SUSP));
    endfunction

endpackage

// File: rtl/fts_sector_lookup.sv
module fts_sector_lookup #(
    parameter int NUM_SECT = 8,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic [SECT_W-1:0]   sect_idx,
    input  logic [NUM_SECT-1:0] sect_mask,
    output logic                hit
);

    logic [NUM_SECT-1:0] onehot;

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_dec
        assign onehot[g] = (sect_idx == SECT_W'(g));
    end

    assign hit = |(onehot & sect_mask);

endmodule

// File: rtl/fts_abort_timer.sv
module fts_abort_timer #(
    parameter int ERASE_ABORT_CYC = 25000,
    parameter int PROG_ABORT_CYC  = 250,
    localparam int MAX_CYC = (ERASE_ABORT_CYC > PROG_ABORT_CYC) ? ERASE_ABORT_CYC : PROG_ABORT_CYC,
    localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_erase,
    output logic active,
    output logic active_erase
);

    localparam logic [CNT_W-1:0] ERS_LOAD = CNT_W'(ERASE_ABORT_CYC - 1);
    localparam logic [CNT_W-1:0] PRG_LOAD = CNT_W'(PROG_ABORT_CYC - 1);

    typedef struct packed {
        logic             run;
        logic             ers;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
                tmr_d.ers = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.ers = start_erase;
            tmr_d.cnt = start_erase ? ERS_LOAD : PRG_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign active       = tmr_q.run;
    assign active_erase = tmr_q.run & tmr_q.ers;

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.run |-> (tmr_q.cnt <= (tmr_q.ers ? ERS_LOAD : PRG_LOAD)));

    assert_abort_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_q.run) |-> ($past(tmr_q.cnt) == '0));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tmr_q.run);

endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
    import fts_pkg::*;
#(
    parameter int NUM_SECT        = 8,
    parameter int ADDR_W          = 12,
    parameter int ERASE_ABORT_CYC = 25000,
    parameter int PROG_ABORT_CYC  = 250
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_state,
    input  logic                cmd_commit,
    input  logic                cmd_erase,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [NUM_SECT-1:0] erase_sel,
    input  logic [NUM_SECT-1:0] prot_mask,
    input  logic                rd_strobe,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                dq6,
    output logic                dq2,
    output logic                array_mode
);

    localparam int SECT_W = $clog2(NUM_SECT);

    logic       rd_hit, cmd_prot_hit;
    logic       abort_run, abort_ers;
    logic       busy, ers_pend, abort_go;
    logic       unused_addr_bits;
    tog_state_t tog_d, tog_q;

    assign unused_addr_bits = ^{rd_addr[ADDR_W-SECT_W-1:0], cmd_addr[ADDR_W-SECT_W-1:0]};

    fts_sector_lookup #(.NUM_SECT(NUM_SECT)) i_rd_lookup (
        .sect_idx  (rd_addr[ADDR_W-1 -: SECT_W]),
        .sect_mask (erase_sel),
        .hit       (rd_hit)
    );

    fts_sector_lookup #(.NUM_SECT(NUM_SECT)) i_cmd_lookup (
        .sect_idx  (cmd_addr[ADDR_W-1 -: SECT_W]),
        .sect_mask (prot_mask),
        .hit       (cmd_prot_hit)
    );

    fts_abort_timer #(
        .ERASE_ABORT_CYC (ERASE_ABORT_CYC),
        .PROG_ABORT_CYC  (PROG_ABORT_CYC)
    ) i_abort_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (abort_go),
        .start_erase  (cmd_erase),
        .active       (abort_run),
        .active_erase (abort_ers)
    );

    assign busy       = op_is_running(op_state) | abort_run;
    assign ers_pend   = op_erase_pending(op_state) | abort_ers;
    assign array_mode = op_is_idle(op_state) & ~abort_run;

    // Commit is judged only while reads return array data
    always_comb begin
        abort_go = 1'b0;
        if (cmd_commit && array_mode) begin
            if (cmd_erase)
                abort_go = (erase_sel != '0) && ((erase_sel & ~prot_mask) == '0);
            else
                abort_go = cmd_prot_hit;
        end
    end

    always_comb begin
        tog_d = tog_q;
        if (array_mode) begin
            tog_d = '0;
        end else if (rd_strobe) begin
            if (busy)
                tog_d.busy_tog = ~tog_q.busy_tog;
            if (ers_pend && rd_hit)
                tog_d.sect_tog = ~tog_q.sect_tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= '0;
        else        tog_q <= tog_d;
    end

    assign dq6 = tog_q.busy_tog & ~array_mode;
    assign dq2 = tog_q.sect_tog & ~array_mode;

    assert_dq6_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_is_running(op_state)) |=> (tog_q.busy_tog != $past(tog_q.busy_tog)));

    assert_dq6_hold_susp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == OP_ERS_SUSP && !abort_run) |=> $stable(tog_q.busy_tog));

    assert_dq2_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!array_mode && !(rd_strobe && rd_hit)) |=> $stable(tog_q.sect_tog));

    assert_array_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        array_mode |=> (tog_q.busy_tog == 1'b0 && tog_q.sect_tog == 1'b0));

endmodule

// File: tb/test_flash_toggle_status.sv
`timescale 1ns/1ps
module test_flash_toggle_status;

    localparam int NS   = 8;
    localparam int AW   = 12;
    localparam int SW   = 3;
    localparam int ECYC = 40;
    localparam int PCYC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_st = 3'd0;
    logic          cmd_commit = 1'b0;
    logic          cmd_erase = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [NS-1:0] erase_sel = '0;
    logic [NS-1:0] prot_mask = '0;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          dq6, dq2, array_mode;

    always #2 clk = ~clk;

    flash_toggle_status #(
        .NUM_SECT(NS), .ADDR_W(AW), .ERASE_ABORT_CYC(ECYC), .PROG_ABORT_CYC(PCYC)
    ) i_flash_toggle_status (
        .clk(clk), .rst_n(rst_n), .op_state(op_st), .cmd_commit(cmd_commit),
        .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .erase_sel(erase_sel),
        .prot_mask(prot_mask), .rd_strobe(rd_stb), .rd_addr(rd_addr),
        .dq6(dq6), .dq2(dq2), .array_mode(array_mode)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit m6 = 0, m2 = 0, mab = 0, mabe = 0;
    int mrem = 0;
    bit done = 0;

    function automatic bit f_run(logic [2:0] s);
        return s == 3'd1 || s == 3'd2 || s == 3'd3 || s == 3'd5;
    endfunction
    function automatic bit f_epend(logic [2:0] s);
        return s == 3'd2 || s == 3'd3 || s == 3'd4 || s == 3'd5;
    endfunction
    function automatic bit f_idle(logic [2:0] s);
        return s == 3'd0 || s > 3'd5;
    endfunction
    function automatic int sec_of(logic [AW-1:0] a);
        return int'(a >> (AW - SW));
    endfunction
    function automatic logic [AW-1:0] addr_in(int s);
        return AW'((s << (AW - SW)) | ($urandom % (1 << (AW - SW))));
    endfunction

    task automatic model_edge();
        bit arr;
        bit trig;
        arr = f_idle(op_st) && !mab;
        if (arr) begin
            m6 = 0; m2 = 0;
        end else if (rd_stb) begin
            if (f_run(op_st) || mab) m6 = !m6;
            if ((f_epend(op_st) || (mab && mabe)) && erase_sel[sec_of(rd_addr)]) m2 = !m2;
        end
        if (mab) begin
            mrem--;
            if (mrem == 0) begin mab = 0; mabe = 0; end
        end else if (arr && cmd_commit) begin
            if (cmd_erase) trig = (erase_sel != 0) && ((erase_sel & ~prot_mask) == 0);
            else           trig = prot_mask[sec_of(cmd_addr)];
            if (trig) begin
                mab = 1; mabe = cmd_erase; mrem = cmd_erase ? ECYC : PCYC;
            end
        end
    endtask

    task automatic check(string tag);
        bit ea, e6, e2;
        ea = f_idle(op_st) && !mab;
        e6 = ea ? 1'b0 : m6;
        e2 = ea ? 1'b0 : m2;
        n_cmp++;
        if (dq6 !== e6 || dq2 !== e2 || array_mode !== ea) begin
            n_bad++;
            $display("FAIL %s: dq6/dq2/array got %b%b%b exp %b%b%b at %0t",
                     tag, dq6, dq2, array_mode, e6, e2, ea, $time);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
        rd_stb = 0;
        cmd_commit = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        rd_addr = a; rd_stb = 1;
        step(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1;
        step("R1 after release");

        // Program running: busy bit toggles per read, sector bit quiet
        erase_sel = 8'b0000_0110;
        op_st = 3'd1;
        for (int i = 0; i < 5; i++) rd(addr_in(i), "R2 program toggle");
        rd(addr_in(1), "R5 program no sector toggle");
        idle(3, "R2 hold without strobe");

        // Erase time-out then erasing
        op_st = 3'd0; step("R6 back to array");
        op_st = 3'd2;
        rd(addr_in(1), "R4 timeout selected");
        rd(addr_in(5), "R5 timeout unselected");
        op_st = 3'd3;
        for (int i = 0; i < 8; i++) rd(addr_in(i), "R4 R5 erasing sweep");

        // Suspend: busy bit frozen, sector bit still toggles
        op_st = 3'd4;
        for (int i = 0; i < 4; i++) rd(addr_in(2), "R3 R4 suspended selected");
        rd(addr_in(7), "R3 R5 suspended unselected");

        // Suspend-program, then resume
        op_st = 3'd5;
        for (int i = 0; i < 3; i++) rd(addr_in(i), "R2 suspend-program");
        op_st = 3'd4; rd(addr_in(1), "R3 program done in suspend");
        op_st = 3'd3; rd(addr_in(2), "R2 resume");
        op_st = 3'd0; step("R6 erase done");
        rd(addr_in(1), "R6 array read");
        op_st = 3'd7; rd(addr_in(1), "R2 unused code as idle");
        op_st = 3'd0;

        // Program into protected sector: abort of PCYC cycles
        prot_mask = 8'b0001_0000;
        cmd_addr = addr_in(4); cmd_erase = 0; cmd_commit = 1;
        step("R7 program abort start");
        for (int i = 0; i < PCYC - 1; i++) rd(addr_in(i), "R7 program abort toggle");
        rd(addr_in(2), "R7 program abort end");
        rd(addr_in(2), "R7 array after abort");

        // Erase with all selected sectors protected
        prot_mask = 8'b0110_0110; erase_sel = 8'b0000_0110;
        cmd_erase = 1; cmd_commit = 1;
        step("R8 erase abort start");
        for (int i = 0; i < ECYC - 1; i++) rd(addr_in(i % NS), "R8 erase abort toggle");
        rd(addr_in(1), "R8 erase abort end");
        rd(addr_in(1), "R8 array after abort");

        // No abort cases
        erase_sel = 8'b0000_0111; cmd_erase = 1; cmd_commit = 1;
        step("R9 partial protection");
        rd(addr_in(1), "R9 partial protection array");
        erase_sel = '0; cmd_commit = 1; step("R9 empty selection");
        cmd_erase = 0; cmd_addr = addr_in(0); cmd_commit = 1; step("R9 unprotected program");
        op_st = 3'd3; erase_sel = 8'b0000_0010;
        cmd_erase = 0; cmd_addr = addr_in(4); cmd_commit = 1;
        rd(addr_in(1), "R9 commit ignored when busy");
        op_st = 3'd0; idle(2, "R9 no abort after busy commit");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 8 == 0) op_st = 3'($urandom % 8);
            if ($urandom % 16 == 0) erase_sel = NS'($urandom);
            if ($urandom % 16 == 0) prot_mask = NS'($urandom);
            if ($urandom % 32 == 0) begin
                cmd_commit = 1; cmd_erase = 1'($urandom); cmd_addr = AW'($urandom);
            end
            rd_addr = AW'($urandom);
            rd_stb = 1'($urandom);
            step("R2 R3 R4 R5 R6 R7 R8 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule